// File: doc/BRIEF.md
# Lockable Monitor Control with PWM Override

This block holds the control byte of a hardware-monitor subsystem, together with a small bank of limit/parameter registers and a set of fan PWM outputs. Software uses the control byte to start monitoring, to force every fan to full speed, and to freeze its configuration with a sticky lock. Once the lock is set, the limit bank and the start and lock bits can no longer be changed. Only a rising edge on the power-good input or a reset releases the lock. The override bit stays writable while the lock is set.

While monitoring is stopped, the bank presents built-in defaults on its effective-value output. The programmed values are kept and can still be read back. Each PWM output runs from a shared 8-bit phase counter that advances once per slow tick, where one tick occurs every `PRESCALE` clocks. In normal mode each channel follows its own duty byte, which it picks up only at a period boundary. When monitoring is stopped, or when the override bit is set, every channel drives the full-duty pattern instead: high for 255 ticks, then low for 1 tick.

All ports are plain level signals: a write strobe with data for the control byte and for the bank, combinational read-back, and level duty inputs. There is no flow control at the edge of the block.

Top module: `fanmon_ctrl`

## Requirements
- R1: The control byte reads back with start at bit 0, lock at bit 1, ready at bit 2 and override at bit 3. Bits 7:4 always read 0.
- R2: A control write while unlocked sets start, lock and override from write bits 0, 1 and 3. Write bits 2 and 7:4 are ignored.
- R3: While lock is 1, control writes leave start and lock unchanged and still update override.
- R4: Lock is cleared one clock after power-good goes from 0 to 1, and by reset. Start is unaffected. Power-good held high, or power-good falling, does not clear the lock.
- R5: A bank write to an address takes effect on the next clock when lock is 0. When lock is 1 the write is ignored and read-back returns the previous value.
- R6: The effective output returns the programmed value when start is 1. When start is 0 it returns the default for the addressed entry, DEF_BASE + index*DEF_STEP (mod 256). Programmed values survive start being toggled.
- R7: Ready becomes 1 one clock after the converter-ready input is seen high after reset, and then stays 1 even if that input falls.
- R8: In full mode every PWM output is high while the phase count is 0..254 and low while it is 255. One period is 256 ticks, and one tick is PRESCALE clocks.
- R9: In normal mode, channel k is high while the phase count is below its latched duty. A new duty byte is latched only on the tick at which the phase count wraps from 255 to 0.
- R10: Full mode follows (start == 0 OR override == 1) at the next slow tick. It does not wait for a period boundary.
- R11: After reset, the control byte reads 00h (ready is still 0), the phase count is 0, and all outputs are in full mode and high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; a rising edge releases the lock |
| adc_ok | input | 1 | Converters report operational |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read-back |
| lim_we | input | 1 | Limit bank write strobe |
| lim_addr | input | LIM_AW | Limit bank entry select (read and write) |
| lim_wdata | input | 8 | Limit bank write data |
| lim_rdata | output | 8 | Programmed value of the selected entry |
| lim_eff | output | 8 | Value in effect for the selected entry (default or programmed) |
| duty_in | input | 8*N_PWM | Per-channel duty bytes, channel k at bits 8k+7:8k |
| pwm_out | output | N_PWM | PWM outputs |

## Verification
The hardest situation to reach is the meeting of three conditions: a locked configuration, an override toggled while locked, and then a power-good edge that must clear only the lock, with start left as it was. The stimulus first programs the bank and starts monitoring. It then locks, tries to clear start and rewrite a limit, sets and clears override, and only then raises power-good. It also holds power-good high, and later drops it, across a second lock to show that neither a held level nor a falling edge releases the lock. The mode-switch latency is reached by latching a zero duty in normal mode, so outputs sit low. The stimulus then clears start and counts the clocks until every output goes high.

// File: rtl/fanmon_pkg.sv
package fanmon_pkg;
  localparam int START_BIT = 0;
  localparam int LOCK_BIT  = 1;
  localparam int READY_BIT = 2;
  localparam int OVR_BIT   = 3;

  typedef struct packed {
    logic ovr;
    logic ready;
    logic lock;
    logic start;
  } ctl_t;

  function automatic logic [7:0] default_limit(input logic [7:0] idx,
                                               input logic [7:0] base,
                                               input logic [7:0] step);
    logic [7:0] prod;
    prod = idx * step;
    return base + prod;
  endfunction
endpackage

// File: rtl/fanmon_ctrl_reg.sv
module fanmon_ctrl_reg
  import fanmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       pwr_good,
  input  logic       adc_ok,
  output ctl_t       ctl_o,
  output logic [7:0] rd_data
);
  logic start_q, lock_q, ovr_q, ready_q, pg_q;
  logic pg_rise;

  assign pg_rise = pwr_good & ~pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      lock_q  <= 1'b0;
      ovr_q   <= 1'b0;
      ready_q <= 1'b0;
      pg_q    <= 1'b0;
    end else begin
      pg_q    <= pwr_good;
      ready_q <= ready_q | adc_ok;
      if (wr_en) begin
        ovr_q <= wr_data[OVR_BIT];
        if (!lock_q) start_q <= wr_data[START_BIT];
      end
      if (pg_rise) lock_q <= 1'b0;
      else if (wr_en && !lock_q) lock_q <= wr_data[LOCK_BIT];
    end
  end

  assign ctl_o = '{ovr: ovr_q, ready: ready_q, lock: lock_q, start: start_q};

  always_comb begin
    rd_data            = '0;
    rd_data[START_BIT] = start_q;
    rd_data[LOCK_BIT]  = lock_q;
    rd_data[READY_BIT] = ready_q;
    rd_data[OVR_BIT]   = ovr_q;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !pg_rise) |=> lock_q); // R4
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rise |=> !lock_q); // R4
  AST_START_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(start_q)); // R3
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q); // R7
endmodule

// File: rtl/fanmon_limit_bank.sv
module fanmon_limit_bank
  import fanmon_pkg::*;
#(
  parameter int         NUM      = 8,
  parameter int         AW       = 3,
  parameter logic [7:0] DEF_BASE = 8'h50,
  parameter logic [7:0] DEF_STEP = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  input  logic          lock,
  input  logic          use_prog,
  output logic [7:0]    prog_o,
  output logic [7:0]    eff_o
);
  logic [NUM-1:0][7:0] mem_q;
  logic [7:0]          def_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) mem_q[i] <= default_limit(8'(i), DEF_BASE, DEF_STEP);
    end else if (wr_en && !lock) begin
      for (int i = 0; i < NUM; i++)
        if (addr == AW'(i)) mem_q[i] <= wr_data;
    end
  end

  generate
    if (NUM == (1 << AW)) begin : g_full_map
      assign prog_o = mem_q[addr];
    end else begin : g_part_map
      assign prog_o = (32'(addr) < NUM) ? mem_q[addr] : 8'h00;
    end
  endgenerate

  assign def_sel = default_limit(8'(addr), DEF_BASE, DEF_STEP);
  assign eff_o   = use_prog ? prog_o : def_sel;

  AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem_q)); // R5
endmodule

// File: rtl/fanmon_pwm_timebase.sv
module fanmon_pwm_timebase #(
  parameter int PRESCALE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_full,
  output logic       tick,
  output logic       period_end,
  output logic [7:0] cnt,
  output logic       full
);
  logic [7:0] cnt_q;
  logic       full_q;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pre_q <= '0;
        else if (pre_q == PW'(PRESCALE - 1)) pre_q <= '0;
        else                                 pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 8'h00;
      full_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= cnt_q + 8'd1;
      full_q <= force_full;
    end
  end

  assign period_end = tick & (cnt_q == 8'hFF);
  assign cnt        = cnt_q;
  assign full       = full_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 8'd1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/fanmon_pwm_chan.sv
module fanmon_pwm_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] duty_in,
  input  logic [7:0] cnt,
  input  logic       full,
  output logic       pwm_o
);
  logic [7:0] duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_q <= 8'h00;
    else if (load) duty_q <= duty_in;
  end

  assign pwm_o = full ? (cnt != 8'hFF) : (cnt < duty_q);

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_q)); // R9
endmodule

// File: rtl/fanmon_ctrl.sv
module fanmon_ctrl
  import fanmon_pkg::*;
#(
  parameter int         N_PWM    = 4,
  parameter int         NUM_LIM  = 8,
  parameter int         PRESCALE = 4,
  parameter logic [7:0] DEF_BASE = 8'h50,
  parameter logic [7:0] DEF_STEP = 8'h0B,
  localparam int        LIM_AW   = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic               adc_ok,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               lim_we,
  input  logic [LIM_AW-1:0]  lim_addr,
  input  logic [7:0]         lim_wdata,
  output logic [7:0]         lim_rdata,
  output logic [7:0]         lim_eff,
  input  logic [8*N_PWM-1:0] duty_in,
  output logic [N_PWM-1:0]   pwm_out
);
  ctl_t       ctl;
  logic       tick, period_end, full;
  logic [7:0] cnt;

  fanmon_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .pwr_good(pwr_good),
    .adc_ok  (adc_ok),
    .ctl_o   (ctl),
    .rd_data (cfg_rdata)
  );

  fanmon_limit_bank #(
    .NUM     (NUM_LIM),
    .AW      (LIM_AW),
    .DEF_BASE(DEF_BASE),
    .DEF_STEP(DEF_STEP)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lim_we),
    .addr    (lim_addr),
    .wr_data (lim_wdata),
    .lock    (ctl.lock),
    .use_prog(ctl.start),
    .prog_o  (lim_rdata),
    .eff_o   (lim_eff)
  );

  fanmon_pwm_timebase #(.PRESCALE(PRESCALE)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_full(~ctl.start | ctl.ovr),
    .tick      (tick),
    .period_end(period_end),
    .cnt       (cnt),
    .full      (full)
  );

  generate
    for (genvar k = 0; k < N_PWM; k++) begin : g_chan
      fanmon_pwm_chan u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (period_end),
        .duty_in(duty_in[8*k +: 8]),
        .cnt    (cnt),
        .full   (full),
        .pwm_o  (pwm_out[k])
      );
    end
  endgenerate

  AST_EXIT_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (!ctl.start || ctl.ovr)) |=> full); // R10
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cnt != 8'hFF) |-> (pwm_out == '1)); // R8
  AST_FULL_LOW_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cnt == 8'hFF) |-> (pwm_out == '0)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:4] == 4'h0); // R1
endmodule

// File: tb/tb_fanmon_ctrl.sv
module tb_fanmon_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_PWM      = 4;
  localparam int NUM_LIM    = 8;
  localparam int PRESCALE   = 4;
  localparam int LIM_AW     = 3;
  localparam int DEF_BASE   = 'h50;
  localparam int DEF_STEP   = 'h0B;
  localparam int PERIOD_CLK = 256 * PRESCALE;

  logic               clk = 1'b0;
  logic               rst_n, pwr_good, adc_ok, cfg_we, lim_we;
  logic [7:0]         cfg_wdata, cfg_rdata, lim_wdata, lim_rdata, lim_eff;
  logic [LIM_AW-1:0]  lim_addr;
  logic [8*N_PWM-1:0] duty_in;
  logic [N_PWM-1:0]   pwm_out;

  fanmon_ctrl #(
    .N_PWM(N_PWM), .NUM_LIM(NUM_LIM), .PRESCALE(PRESCALE),
    .DEF_BASE(8'(DEF_BASE)), .DEF_STEP(8'(DEF_STEP))
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .adc_ok(adc_ok),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lim_we(lim_we), .lim_addr(lim_addr), .lim_wdata(lim_wdata),
    .lim_rdata(lim_rdata), .lim_eff(lim_eff),
    .duty_in(duty_in), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int def_val(input int i);
    return (DEF_BASE + i * DEF_STEP) % 256;
  endfunction

  // behavioural reference model
  int m_start = 0, m_lock = 0, m_ovr = 0, m_ready = 0, m_pg = 0;
  int m_pre = 0, m_cnt = 0, m_full = 1;
  int m_lim[NUM_LIM];
  int m_duty[N_PWM];

  initial begin
    for (int i = 0; i < NUM_LIM; i++) m_lim[i] = def_val(i);
    for (int i = 0; i < N_PWM; i++) m_duty[i] = 0;
  end

  always @(posedge clk) begin : model
    int cs, cl, co;
    bit rise;
    if (!rst_n) begin
      m_start = 0; m_lock = 0; m_ovr = 0; m_ready = 0; m_pg = 0;
      m_pre = 0; m_cnt = 0; m_full = 1;
      for (int i = 0; i < NUM_LIM; i++) m_lim[i] = def_val(i);
      for (int i = 0; i < N_PWM; i++) m_duty[i] = 0;
    end else begin
      cs = m_start; cl = m_lock; co = m_ovr;
      rise = pwr_good && (m_pg == 0);
      m_pg = pwr_good ? 1 : 0;
      if (adc_ok) m_ready = 1;
      if (cfg_we) begin
        m_ovr = cfg_wdata[3] ? 1 : 0;
        if (cl == 0) m_start = cfg_wdata[0] ? 1 : 0;
      end
      if (rise) m_lock = 0;
      else if (cfg_we && cl == 0) m_lock = cfg_wdata[1] ? 1 : 0;
      if (lim_we && cl == 0) m_lim[lim_addr] = lim_wdata;
      if (m_pre == PRESCALE - 1) begin
        m_pre = 0;
        if (m_cnt == 255)
          for (int i = 0; i < N_PWM; i++) m_duty[i] = duty_in[8*i +: 8];
        m_full = (cs == 0 || co != 0) ? 1 : 0;
        m_cnt  = (m_cnt + 1) % 256;
      end else begin
        m_pre++;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin : compare
    int exp_cfg, exp_eff, exp_pwm;
    if (rst_n === 1'b1 && !done) begin
      exp_cfg = m_start | (m_lock << 1) | (m_ready << 2) | (m_ovr << 3);
      chk(cfg_rdata == 8'(exp_cfg), "R1 control read-back", cfg_rdata, exp_cfg);
      chk(lim_rdata == 8'(m_lim[lim_addr]), "R5 programmed read-back", lim_rdata, m_lim[lim_addr]);
      exp_eff = m_start ? m_lim[lim_addr] : def_val(int'(lim_addr));
      chk(lim_eff == 8'(exp_eff), "R6 effective value", lim_eff, exp_eff);
      exp_pwm = 0;
      for (int i = 0; i < N_PWM; i++) begin
        if (m_full) exp_pwm |= (m_cnt != 255) << i;
        else        exp_pwm |= (m_cnt < m_duty[i]) << i;
      end
      chk(pwm_out == N_PWM'(exp_pwm), m_full ? "R8 full pattern" : "R9 normal duty",
          pwm_out, exp_pwm);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic lim_write(input int a, input logic [7:0] d);
    lim_we = 1'b1; lim_addr = LIM_AW'(a); lim_wdata = d;
    @(posedge clk); #1;
    lim_we = 1'b0;
  endtask

  task automatic count_high(input int idx, input int n, output int c);
    c = 0;
    repeat (n) begin @(posedge clk); #1; if (pwm_out[idx]) c++; end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int c, k;
    rst_n = 1'b0; pwr_good = 1'b0; adc_ok = 1'b0; cfg_we = 1'b0; lim_we = 1'b0;
    cfg_wdata = 8'h00; lim_wdata = 8'h00; lim_addr = '0; duty_in = '0;
    idle(3);
    rst_n = 1'b1;
    #1;
    chk(cfg_rdata == 8'h00, "R11 reset control byte", cfg_rdata, 8'h00);
    chk(pwm_out == '1, "R11 reset outputs full-on", pwm_out, 4'hF);

    // R7: ready
    adc_ok = 1'b1; idle(1); adc_ok = 1'b0;
    chk(cfg_rdata == 8'h04, "R7 ready set", cfg_rdata, 8'h04);
    idle(3);
    chk(cfg_rdata == 8'h04, "R7 ready sticky", cfg_rdata, 8'h04);

    // R5/R6: program bank while stopped
    for (int i = 0; i < NUM_LIM; i++) lim_write(i, 8'(8'hA0 + i * 3));
    for (int i = 0; i < NUM_LIM; i++) begin
      lim_addr = LIM_AW'(i); #1;
      chk(lim_rdata == 8'(8'hA0 + i * 3), "R5 write when unlocked", lim_rdata, 8'hA0 + i * 3);
      chk(lim_eff == 8'(def_val(i)), "R6 default while stopped", lim_eff, def_val(i));
    end

    // R2/R9: start monitoring
    duty_in = {8'hFF, 8'h00, 8'h80, 8'h40};
    cfg_write(8'h01);
    chk(cfg_rdata == 8'h05, "R2 start written", cfg_rdata, 8'h05);
    lim_addr = 3'd2; #1;
    chk(lim_eff == 8'hA6, "R6 programmed while started", lim_eff, 8'hA6);
    idle(PERIOD_CLK + 10);
    count_high(0, PERIOD_CLK, c);
    chk(c == 'h40 * PRESCALE, "R9 duty 40h high time", c, 'h40 * PRESCALE);
    count_high(1, PERIOD_CLK, c);
    chk(c == 'h80 * PRESCALE, "R9 duty 80h high time", c, 'h80 * PRESCALE);
    count_high(2, PERIOD_CLK, c);
    chk(c == 0, "R9 duty 00h high time", c, 0);

    cfg_write(8'hF5);
    chk(cfg_rdata == 8'h05, "R2 reserved bits ignored", cfg_rdata, 8'h05);

    // R10: exit to full mode within a tick
    duty_in = '0;
    idle(PERIOD_CLK + 5);
    chk(pwm_out == '0, "R9 zero duty latched", pwm_out, 0);
    cfg_write(8'h00);
    k = 0;
    while (pwm_out != '1 && k < 50) begin @(posedge clk); #1; k++; end
    chk(k <= 2 * PRESCALE, "R10 full mode latency", k, 2 * PRESCALE);
    lim_addr = 3'd5; #1;
    chk(lim_eff == 8'(def_val(5)), "R6 default after stop", lim_eff, def_val(5));
    chk(lim_rdata == 8'hAF, "R6 programmed preserved", lim_rdata, 8'hAF);
    count_high(3, PERIOD_CLK, c);
    chk(c == 255 * PRESCALE, "R8 full-duty high time", c, 255 * PRESCALE);

    // override
    cfg_write(8'h01);
    idle(2 * PRESCALE + 2);
    chk(pwm_out == '0, "R9 back to zero duty", pwm_out, 0);
    cfg_write(8'h09);
    idle(2 * PRESCALE + 2);
    count_high(1, PERIOD_CLK, c);
    chk(c == 255 * PRESCALE, "R8 override full duty", c, 255 * PRESCALE);
    cfg_write(8'h01);

    // R3: lock
    cfg_write(8'h03);
    chk(cfg_rdata == 8'h07, "R3 lock set", cfg_rdata, 8'h07);
    cfg_write(8'h00);
    chk(cfg_rdata == 8'h07, "R3 start/lock frozen", cfg_rdata, 8'h07);
    cfg_write(8'h08);
    chk(cfg_rdata == 8'h0F, "R3 override writable while locked", cfg_rdata, 8'h0F);
    idle(2 * PRESCALE + 2);
    cfg_write(8'h00);
    chk(cfg_rdata == 8'h07, "R3 override cleared while locked", cfg_rdata, 8'h07);

    // R5: locked bank write ignored
    lim_write(1, 8'h11);
    lim_addr = 3'd1; #1;
    chk(lim_rdata == 8'hA3, "R5 locked write ignored", lim_rdata, 8'hA3);

    // R4: power-good
    pwr_good = 1'b1; idle(1);
    chk(cfg_rdata == 8'h05, "R4 power-good releases lock", cfg_rdata, 8'h05);
    idle(3);
    cfg_write(8'h03);
    idle(3);
    chk(cfg_rdata == 8'h07, "R4 held power-good keeps lock", cfg_rdata, 8'h07);
    pwr_good = 1'b0; idle(2);
    chk(cfg_rdata == 8'h07, "R4 falling power-good keeps lock", cfg_rdata, 8'h07);
    pwr_good = 1'b1; idle(1);
    chk(cfg_rdata == 8'h05, "R4 second rise releases lock", cfg_rdata, 8'h05);

    lim_write(1, 8'h11);
    lim_addr = 3'd1; #1;
    chk(lim_rdata == 8'h11, "R5 write after release", lim_rdata, 8'h11);

    idle(300);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule